// File: doc/BRIEF.md
# LCD Segment Blink Controller

This block sits between the segment data storage of an LCD subsystem and its waveform generator. It keeps two banks of segment bits: an on/off bank that says which segments are lit, and a blink-enable bank that says which segments take part in blinking. Software reaches both banks through one data window of byte registers. A bank-select bit in the command/status register picks which bank the window addresses.

A blink phase is derived from a waveform base clock tick through a power-of-two divider. During the off half of the blink period the block forces segments dark. Either only the blink-enabled segments are forced dark, or the whole panel is. Blink start and stop requests wait for the next frame-start pulse before they take effect.

The block also keeps an interrupt flag. The flag is raised at frame boundaries while enabled. It is cleared only by a read of the command/status register that sees the flag set, followed by a write of one to the flag bit.

Top module: `seg_blink_top`

## Requirements
- R1: After reset, segOut is zero, irqOut is zero, and the command/status register (address 0) and the blink control register (address 1) read as zero.
- R2: Addresses 2 to 2+NUM_WORDS-1 form the data window. Address 2+k holds byte k of a bank, and bit i of that byte is segment 8k+i. The window reaches the on/off bank when command bit 1 is 0 and the blink-enable bank when it is 1. Writes and reads follow the same selection.
- R3: While blinking is inactive, segOut equals the on/off bank, and a window write is visible on segOut in the cycle after the write edge.
- R4: The blink request (control bit 0) is sampled only on a frameStart pulse, and a request to stop is applied the same way. Between pulses, a changed request leaves the output pattern unaffected.
- R5: With control bit 1 at 0, the off phase forces low only those segments whose blink-enable bit is set. All other segments keep their on/off value.
- R6: With control bit 1 at 1, the off phase forces every segment low. The bit has no effect while blinking is inactive.
- R7: Blinking starts in the on phase. The phase toggles after every 2^(4+rate) baseTick pulses, where rate is control bits [4:2]. This gives a blink period of 2^(5+rate) base ticks.
- R8: Each frameStart pulse sets the interrupt flag while command bit 3 (interrupt enable) is 1. The flag reads in command bit 0 and drives irqOut.
- R9: Writing 1 to command bit 0 clears the flag only if a read of address 0 has returned the flag set since that read was last used for a clear. A write of 1 without such a read, or any write of 0, leaves the flag unchanged.
- R10: When a frame-boundary set and a valid clear fall in the same cycle, the flag stays set.
- R11: Writing 1 to command bit 2 clears the whole on/off bank at the next edge and leaves the blink-enable bank unchanged. The bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse per waveform base clock period |
| frameStart | input | 1 | One-cycle pulse at each frame boundary |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| segOut | output | 8*NUM_WORDS | Masked segment vector |
| irqOut | output | 1 | Interrupt flag |

## Verification
The interrupt flag can receive a frame-boundary set and a software clear in the same cycle. The bench provokes this by arming the clear with a read and then driving frameStart together with the write of one to the flag. The flag must stay high, and a further write of one without a new read must still not clear it. Blink start and stop also coincide with frame pulses. Mode and request writes are placed in mid-frame, and the bench confirms that the output pattern changes only after the pulse.

// File: rtl/seg_blink_pkg.sv
package seg_blink_pkg;
  // command/status register bit positions
  localparam int CMD_FLAG = 0;
  localparam int CMD_BANK = 1;
  localparam int CMD_CLR  = 2;
  localparam int CMD_IRQE = 3;
  // blink control register bit positions
  localparam int CTL_REQ   = 0;
  localparam int CTL_WHOLE = 1;
  localparam int CTL_RATE  = 2;

  typedef struct packed {
    logic wrOn;
    logic wrBlk;
    logic clrOn;
    logic startBlink;
    logic blinkOn;
    logic wholePanel;
    logic bankSel;
  } dpStrobes_t;
endpackage

// File: rtl/seg_blink_div.sv
module seg_blink_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              restart,
  input  logic              baseTick,
  input  logic [RATE_W-1:0] rate,
  output logic              phaseOff
);
  localparam int CNT_W = 5 + (2**RATE_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = (CNT_W'(1) << (CNT_W'(4) + CNT_W'(rate))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !run || restart) begin
      cnt      <= '0;
      phaseOff <= 1'b0;
    end else if (baseTick) begin
      if (cnt == lastCnt) begin
        cnt      <= '0;
        phaseOff <= ~phaseOff;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/seg_blink_ctrl.sv
module seg_blink_ctrl
  import seg_blink_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_WORDS = 4,
  parameter int RATE_W    = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        dpRdWord,
  output dpStrobes_t        strb,
  output logic [IDX_W-1:0]  segIdx,
  output logic [RATE_W-1:0] rate,
  output logic              irqOut,
  output logic              irqEnable
);
  localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SEG_FIRST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SEG_LAST  = ADDR_W'(2 + NUM_WORDS - 1);

  logic bankSel, irqEn, blinkReq, wholeMode, blinkOn, flag, armed;
  logic [RATE_W-1:0] rateReg;
  logic cmdHit, ctlHit, segHit;
  logic flagSet, flagClrTry, flagClr;

  assign cmdHit = (addr == ADDR_CMD);
  assign ctlHit = (addr == ADDR_CTL);
  assign segHit = (addr >= SEG_FIRST) && (addr <= SEG_LAST);
  assign segIdx = IDX_W'(addr - SEG_FIRST);

  assign flagSet    = frameStart && irqEn;
  assign flagClrTry = wrEn && cmdHit && wrData[CMD_FLAG];
  assign flagClr    = flagClrTry && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel   <= 1'b0;
      irqEn     <= 1'b0;
      blinkReq  <= 1'b0;
      wholeMode <= 1'b0;
      rateReg   <= '0;
      blinkOn   <= 1'b0;
    end else begin
      if (wrEn && cmdHit) begin
        bankSel <= wrData[CMD_BANK];
        irqEn   <= wrData[CMD_IRQE];
      end
      if (wrEn && ctlHit) begin
        blinkReq  <= wrData[CTL_REQ];
        wholeMode <= wrData[CTL_WHOLE];
        rateReg   <= wrData[CTL_RATE +: RATE_W];
      end
      if (frameStart) blinkOn <= blinkReq;
    end
  end

  // flag with read-arm; a set in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (flagSet)      flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;

      if (flagClr || !flag)          armed <= 1'b0;
      else if (rdEn && cmdHit)       armed <= 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.wrOn       = wrEn && segHit && !bankSel;
    strb.wrBlk      = wrEn && segHit && bankSel;
    strb.clrOn      = wrEn && cmdHit && wrData[CMD_CLR];
    strb.startBlink = frameStart && blinkReq && !blinkOn;
    strb.blinkOn    = blinkOn;
    strb.wholePanel = wholeMode;
    strb.bankSel    = bankSel;
  end

  always_comb begin
    rdData = '0;
    if (cmdHit) begin
      rdData[CMD_FLAG] = flag;
      rdData[CMD_BANK] = bankSel;
      rdData[CMD_IRQE] = irqEn;
    end else if (ctlHit) begin
      rdData[CTL_REQ]              = blinkReq;
      rdData[CTL_WHOLE]            = wholeMode;
      rdData[CTL_RATE +: RATE_W]   = rateReg;
    end else if (segHit) begin
      rdData = dpRdWord;
    end
  end

  assign rate      = rateReg;
  assign irqOut    = flag;
  assign irqEnable = irqEn;
endmodule

// File: rtl/seg_blink_dp.sv
module seg_blink_dp
  import seg_blink_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int RATE_W    = 3,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobes_t             strb,
  input  logic [IDX_W-1:0]       segIdx,
  input  logic [7:0]             segByte,
  input  logic [RATE_W-1:0]      rate,
  input  logic                   baseTick,
  output logic [7:0]             rdWord,
  output logic [8*NUM_WORDS-1:0] segOut,
  output logic                   phaseOff
);
  localparam int NUM_SEG = 8 * NUM_WORDS;

  logic [7:0] onBank  [NUM_WORDS];
  logic [7:0] blkBank [NUM_WORDS];
  logic [NUM_SEG-1:0] onFlat, blkFlat, offMask;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrOn) onBank[w] <= '0;
      else if (strb.wrOn && segIdx == IDX_W'(w)) onBank[w] <= segByte;
    end
    always_ff @(posedge clk) begin
      if (!rstN) blkBank[w] <= '0;
      else if (strb.wrBlk && segIdx == IDX_W'(w)) blkBank[w] <= segByte;
    end
    assign onFlat[8*w +: 8]  = onBank[w];
    assign blkFlat[8*w +: 8] = blkBank[w];
  end

  seg_blink_div #(.RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .run      (strb.blinkOn),
    .restart  (strb.startBlink),
    .baseTick (baseTick),
    .rate     (rate),
    .phaseOff (phaseOff)
  );

  assign rdWord  = strb.bankSel ? blkBank[segIdx] : onBank[segIdx];
  assign offMask = strb.wholePanel ? {NUM_SEG{1'b1}} : blkFlat;
  assign segOut  = (strb.blinkOn && phaseOff) ? (onFlat & ~offMask) : onFlat;
endmodule

// File: rtl/seg_blink_top.sv
module seg_blink_top
  import seg_blink_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_WORDS = 4,
  parameter int RATE_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseTick,
  input  logic                   frameStart,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  output logic [8*NUM_WORDS-1:0] segOut,
  output logic                   irqOut
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  dpStrobes_t        strb;
  logic [IDX_W-1:0]  segIdx;
  logic [RATE_W-1:0] rate;
  logic [7:0]        dpRdWord;
  logic              phaseOff, irqEnable, blinkOn, wholePanel;

  seg_blink_ctrl #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RATE_W(RATE_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .dpRdWord(dpRdWord),
    .strb(strb), .segIdx(segIdx), .rate(rate), .irqOut(irqOut), .irqEnable(irqEnable)
  );

  seg_blink_dp #(.NUM_WORDS(NUM_WORDS), .RATE_W(RATE_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .segIdx(segIdx), .segByte(wrData),
    .rate(rate), .baseTick(baseTick), .rdWord(dpRdWord), .segOut(segOut), .phaseOff(phaseOff)
  );

  assign blinkOn    = strb.blinkOn;
  assign wholePanel = strb.wholePanel;
endmodule

// File: rtl/seg_blink_chk.sv
module seg_blink_chk #(
  parameter int ADDR_W = 4,
  parameter int NSEG   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic [NSEG-1:0]   segOut,
  input logic              irqOut,
  input logic              blinkOn,
  input logic              phaseOff,
  input logic              wholePanel,
  input logic              irqEnable
);
  // R4
  blink_frame_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(blinkOn));
  // R6
  whole_panel_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blinkOn && phaseOff && wholePanel) |-> (segOut == '0));
  // R7
  start_on_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blinkOn) |-> !phaseOff);
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && irqEnable) |=> irqOut);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(wrEn && addr == '0 && wrData[0])) |=> irqOut);
  // R11
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0) |-> !rdData[2]);
endmodule

bind seg_blink_top seg_blink_chk #(.ADDR_W(ADDR_W), .NSEG(8*NUM_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .wrData(wrData), .rdData(rdData), .segOut(segOut), .irqOut(irqOut),
  .blinkOn(blinkOn), .phaseOff(phaseOff), .wholePanel(wholePanel), .irqEnable(irqEnable)
);

// File: tb/test_seg_blink_top.sv
`timescale 1ns/1ps
module test_seg_blink_top;
  logic clk = 0;
  logic rstN = 0;
  logic baseTick = 1;
  logic frameStart = 0;
  logic wrEn = 0;
  logic rdEn = 0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [31:0] segOut;
  logic irqOut;

  int checkCount = 0;
  int failCount = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_blink_top i_seg_blink_top (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .frameStart(frameStart),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .segOut(segOut), .irqOut(irqOut)
  );

  // {bankSel, wordIdx[1:0], data[7:0]}
  localparam logic [10:0] WIN_VEC [6] = '{11'h0A5, 11'h13C, 11'h2FF, 11'h381, 11'h40F, 11'h6F0};
  localparam logic [31:0] ON_ALL  = 32'h81FF3CA5;
  localparam logic [31:0] ON_MASK = 32'h810F3CA0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulseFrame();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 segOut", segOut, 0);
    chk("R1 irqOut", {31'b0, irqOut}, 0);
    busRead(4'd0, rd); chk("R1 cmd", {24'b0, rd}, 0);
    busRead(4'd1, rd); chk("R1 ctl", {24'b0, rd}, 0);

    // table walk: fill both banks through the window
    for (int i = 0; i < 6; i++) begin
      busWrite(4'd0, {6'b0, WIN_VEC[i][10], 1'b0});
      busWrite(4'(2 + WIN_VEC[i][9:8]), WIN_VEC[i][7:0]);
    end
    chk("R3 segOut follows on bank", segOut, ON_ALL);
    for (int i = 0; i < 6; i++) begin
      busWrite(4'd0, {6'b0, WIN_VEC[i][10], 1'b0});
      busRead(4'(2 + WIN_VEC[i][9:8]), rd);
      chk("R2 window readback", {24'b0, rd}, {24'b0, WIN_VEC[i][7:0]});
    end
    busWrite(4'd0, 8'h00);

    // R4 request waits for frame
    busWrite(4'd1, 8'h01);
    repeat (40) @(negedge clk);
    chk("R4 no blink before frame", segOut, ON_ALL);
    pulseFrame();
    repeat (15) @(negedge clk);
    chk("R7 on phase first", segOut, ON_ALL);
    @(negedge clk);
    chk("R5 per-segment off phase", segOut, ON_MASK);
    repeat (16) @(negedge clk);
    chk("R7 toggle back on", segOut, ON_ALL);

    // stop, with whole-panel mode selected while stopping
    busWrite(4'd1, 8'h02);
    pulseFrame();
    repeat (40) @(negedge clk);
    chk("R6 whole mode no effect when inactive", segOut, ON_ALL);

    busWrite(4'd1, 8'h03);
    pulseFrame();
    repeat (16) @(negedge clk);
    chk("R6 whole panel dark", segOut, 0);
    busWrite(4'd1, 8'h02);
    chk("R4 stop waits for frame", segOut, 0);
    pulseFrame();
    chk("R4 stop at frame", segOut, ON_ALL);

    // R7 rate 1: half period 32 ticks
    busWrite(4'd1, 8'h05);
    pulseFrame();
    repeat (31) @(negedge clk);
    chk("R7 rate1 still on", segOut, ON_ALL);
    @(negedge clk);
    chk("R7 rate1 off", segOut, ON_MASK);
    busWrite(4'd1, 8'h00);
    pulseFrame();

    // R11 clear command
    busWrite(4'd0, 8'h04);
    chk("R11 on bank cleared", segOut, 0);
    busRead(4'd0, rd); chk("R11 clear bit reads zero", {31'b0, rd[2]}, 0);
    busWrite(4'd0, 8'h02);
    busRead(4'd2, rd); chk("R11 blink bank kept", {24'b0, rd}, 32'h0F);

    // R8/R9 interrupt flag
    busWrite(4'd0, 8'h08);
    pulseFrame();
    chk("R8 flag set", {31'b0, irqOut}, 1);
    busWrite(4'd0, 8'h09);
    chk("R9 write1 without read", {31'b0, irqOut}, 1);
    busRead(4'd0, rd); chk("R8 flag reads 1", {31'b0, rd[0]}, 1);
    busWrite(4'd0, 8'h08);
    chk("R9 write0 no effect", {31'b0, irqOut}, 1);
    busWrite(4'd0, 8'h09);
    chk("R9 read then write1 clears", {31'b0, irqOut}, 0);

    // R10 set and clear in the same cycle
    pulseFrame();
    busRead(4'd0, rd);
    @(negedge clk); addr = 4'd0; wrData = 8'h09; wrEn = 1; frameStart = 1;
    @(negedge clk); wrEn = 0; frameStart = 0;
    chk("R10 set wins", {31'b0, irqOut}, 1);
    busWrite(4'd0, 8'h09);
    chk("R9 arm consumed", {31'b0, irqOut}, 1);
    busRead(4'd0, rd);
    busWrite(4'd0, 8'h01);
    chk("R9 final clear", {31'b0, irqOut}, 0);

    done = 1;
    finishRun();
  end
endmodule